// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block controls a 16-step binary search that turns a held analog sample into a digital code. On each step it presents a trial code to an external capacitor DAC and comparator, and it takes back one comparator decision. The most significant bit is resolved first. A hold/track control freezes the sample/hold for the length of the conversion. An active-low busy flag tells the system when a result is ready.

The search runs in offset binary. The stored result is in two's complement, formed by inverting the top bit of the final search code. The result register keeps the previous conversion until a new conversion completes. A conversion can be cut short by a second start or by a dedicated abort pulse. An aborted conversion writes no result, and the sequencer returns to tracking. Every conversion, whether it completes or aborts, is followed by a minimum acquisition window in which starts are ignored. The number of clock cycles per bit trial is a parameter, so the conversion time can be matched to the analog settling time.

Top module: `sar_conv_seq`

## Requirements
- R1: Conversion resolves W=16 bits, MSB first. The first trial code presented is 0x8000 (offset binary). Each trial lasts CYC_PER_BIT cycles. The comparator bit is sampled on the last cycle of a trial: 1 keeps the trial bit and 0 clears it. The next lower bit is then set as the new trial.
- R2: A start pulse while tracking and idle makes hold_o go high and busy_n_o go low in the next cycle.
- R3: busy_n_o stays low for W*CYC_PER_BIT+1 cycles. The result register updates one cycle before busy_n_o rises.
- R4: While a conversion runs, result_o keeps the previous conversion's value.
- R5: A start_i or abort_i pulse during a conversion ends it. In the next cycle hold_o is low and busy_n_o is high, and result_o is unchanged.
- R6: After a completed or aborted conversion, a start_i pulse is ignored for ACQ_CYCLES cycles. During that window hold_o is low (tracking).
- R7: result_o is the two's complement form of the final search code. Input codes +full scale, midscale, one LSB below midscale and −full scale give 0x7FFF, 0x0000, 0xFFFF and 0x8000.
- R8: While reset is asserted, busy_n_o is 1, hold_o is 0, trial_o is 0 and result_o is 0.
- R9: An abort_i pulse while no conversion is running has no effect. busy_n_o stays high, hold_o stays low and result_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; during a conversion it aborts |
| abort_i | input | 1 | Abort pulse |
| cmp_i | input | 1 | Comparator decision: 1 when input is at or above the trial level |
| trial_o | output | 16 | Offset-binary trial code to the DAC |
| hold_o | output | 1 | 1 = sample/hold in hold, 0 = tracking |
| busy_n_o | output | 1 | Low while a conversion is running |
| result_o | output | 16 | Two's complement result of the last completed conversion |

## Verification
The bench builds the block with W=16, CYC_PER_BIT=3 and ACQ_CYCLES=6. These values keep every conversion to about fifty cycles while still giving multi-cycle trials. That makes the sampling point of the comparator within a trial observable, and it lets a start be placed inside the acquisition window. The short acquisition window also allows aborts at an early step of the search and a run of code-space corner values within a small cycle budget.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_TRACK = 2'd0,
    ST_CONV  = 2'd1,
    ST_DONE  = 2'd2,
    ST_ACQ   = 2'd3
  } sar_state_t;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int W           = 16,
  parameter int CYC_PER_BIT = 4,
  parameter int ACQ_CYCLES  = 8,
  localparam int BW = (W > 1) ? $clog2(W) : 1,
  localparam int CW = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1,
  localparam int AW = (ACQ_CYCLES > 1) ? $clog2(ACQ_CYCLES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          abort_i,
  output sar_state_t    state_o,
  output logic          go_o,
  output logic          decide_o,
  output logic          kill_o,
  output logic          load_o,
  output logic [BW-1:0] bit_idx_o
);

  sar_state_t    state_q, state_d;
  logic [CW-1:0] cyc_q, cyc_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [AW-1:0] acq_q, acq_d;
  logic          cyc_en, bit_en, acq_en;
  logic          in_conv, in_acq;

  assign in_conv  = (state_q == ST_CONV);
  assign in_acq   = (state_q == ST_ACQ);
  assign go_o     = (state_q == ST_TRACK) && start_i;
  assign kill_o   = in_conv && (start_i || abort_i);
  assign decide_o = in_conv && !kill_o && (cyc_q == CW'(CYC_PER_BIT - 1));
  assign load_o   = decide_o && (bit_q == '0);

  // next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_TRACK: if (go_o) state_d = ST_CONV;
      ST_CONV: begin
        if (kill_o)      state_d = ST_ACQ;
        else if (load_o) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_ACQ;
      ST_ACQ:  if (acq_q == AW'(ACQ_CYCLES - 1)) state_d = ST_TRACK;
      default: state_d = ST_TRACK;
    endcase
  end

  // trial timer and bit pointer
  assign cyc_en = go_o || in_conv;
  assign bit_en = go_o || decide_o;
  always_comb begin
    if (go_o || decide_o) cyc_d = '0;
    else                  cyc_d = cyc_q + CW'(1);
    if (go_o) bit_d = BW'(W - 1);
    else      bit_d = bit_q - BW'(1);
  end

  // acquisition counter
  assign acq_en = kill_o || (state_q == ST_DONE) || in_acq;
  always_comb begin
    if (in_acq) acq_d = acq_q + AW'(1);
    else        acq_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_TRACK;
      cyc_q   <= '0;
      bit_q   <= '0;
      acq_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cyc_en) cyc_q <= cyc_d;
      if (bit_en) bit_q <= bit_d;
      if (acq_en) acq_q <= acq_d;
    end
  end

  assign state_o   = state_q;
  assign bit_idx_o = bit_q;

  AST_ACQ_NO_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACQ) |=> (state_q != ST_CONV)); // R6

endmodule

// File: rtl/sar_search.sv
module sar_search #(
  parameter int W = 16,
  localparam int BW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic          decide_i,
  input  logic          kill_i,
  input  logic [BW-1:0] bit_idx_i,
  input  logic          cmp_i,
  output logic [W-1:0]  code_o,
  output logic [W-1:0]  code_nxt_o
);

  logic [W-1:0] code_q, code_d, step;
  logic         code_en;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < W - 1) begin : g_low
      always_comb begin
        if (bit_idx_i == BW'(i))          step[i] = cmp_i;
        else if (bit_idx_i == BW'(i + 1)) step[i] = 1'b1;
        else                              step[i] = code_q[i];
      end
    end else begin : g_top
      always_comb begin
        if (bit_idx_i == BW'(i)) step[i] = cmp_i;
        else                     step[i] = code_q[i];
      end
    end
  end

  assign code_en = kill_i || go_i || decide_i;
  always_comb begin
    if (kill_i)    code_d = '0;
    else if (go_i) code_d = {1'b1, {(W-1){1'b0}}};
    else           code_d = step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  assign code_o     = code_q;
  assign code_nxt_o = step;

endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] final_i,
  output logic [W-1:0] result_o
);

  logic [W-1:0] res_q, res_d;

  assign res_d = {~final_i[W-1], final_i[W-2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (load_i) res_q <= res_d;
  end

  assign result_o = res_q;

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(res_q)); // R4

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_pkg::*;
#(
  parameter int W           = 16,
  parameter int CYC_PER_BIT = 4,
  parameter int ACQ_CYCLES  = 8,
  localparam int BW = (W > 1) ? $clog2(W) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         abort_i,
  input  logic         cmp_i,
  output logic [W-1:0] trial_o,
  output logic         hold_o,
  output logic         busy_n_o,
  output logic [W-1:0] result_o
);

  sar_state_t    state;
  logic          go, decide, kill, load;
  logic [BW-1:0] bit_idx;
  logic [W-1:0]  code_nxt;

  sar_ctrl #(.W(W), .CYC_PER_BIT(CYC_PER_BIT), .ACQ_CYCLES(ACQ_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .state_o(state), .go_o(go), .decide_o(decide), .kill_o(kill),
    .load_o(load), .bit_idx_o(bit_idx)
  );

  sar_search #(.W(W)) u_search (
    .clk(clk), .rst_n(rst_n), .go_i(go), .decide_i(decide), .kill_i(kill),
    .bit_idx_i(bit_idx), .cmp_i(cmp_i), .code_o(trial_o), .code_nxt_o(code_nxt)
  );

  sar_result #(.W(W)) u_result (
    .clk(clk), .rst_n(rst_n), .load_i(load), .final_i(code_nxt),
    .result_o(result_o)
  );

  assign hold_o   = (state == ST_CONV);
  assign busy_n_o = !((state == ST_CONV) || (state == ST_DONE));

  AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TRACK && start_i) |=> (hold_o && !busy_n_o)); // R2

  AST_LOAD_BEFORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!busy_n_o && !hold_o)); // R3

  AST_ABORT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && (start_i || abort_i)) |=> (!hold_o && busy_n_o && $stable(result_o))); // R5

endmodule

// File: tb/sar_conv_seq_test.sv
module sar_conv_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 16;
  localparam int CPB = 3;
  localparam int ACQ = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         abort_i = 1'b0;
  logic         cmp_i;
  logic [W-1:0] trial_o, result_o;
  logic         hold_o, busy_n_o;
  logic [W-1:0] vin = '0;

  int n_run = 0;
  int n_fail = 0;
  logic [W-1:0] last_res = '0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural DAC + comparator: input at or above trial level
  assign cmp_i = (trial_o <= vin);

  sar_conv_seq #(.W(W), .CYC_PER_BIT(CPB), .ACQ_CYCLES(ACQ)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .cmp_i(cmp_i), .trial_o(trial_o), .hold_o(hold_o),
    .busy_n_o(busy_n_o), .result_o(result_o)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // scoreboard monitor: every rise of busy compares result with queued item
  initial begin
    wait (rst_n);
    forever begin
      @(posedge busy_n_o);
      #1;
      if (exp_q.size() == 0) chk("R5 unexpected busy rise", 16'h0, 16'h1);
      else chk(tag_q.pop_front(), result_o, exp_q.pop_front());
    end
  end

  task automatic wait_free();
    while (!busy_n_o) @(negedge clk);
    repeat (ACQ + 1) @(negedge clk);
  endtask

  task automatic run_conv(input logic [W-1:0] v, input string tag);
    @(negedge clk);
    vin = v ^ 16'h8000;
    start_i = 1'b1;
    exp_q.push_back(v);
    tag_q.push_back(tag);
    @(negedge clk);
    start_i = 1'b0;
    last_res = v;
    wait_free();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired got 0 exp 1");
    finish_run();
  end

  initial begin
    int lowcnt;
    logic [W-1:0] res_last_low;
    repeat (2) @(negedge clk);
    // R8 reset state
    chk("R8 busy_n", {15'b0, busy_n_o}, 16'h1);
    chk("R8 hold", {15'b0, hold_o}, 16'h0);
    chk("R8 trial", trial_o, 16'h0);
    chk("R8 result", result_o, 16'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 / R1 / R3 / R4 detailed conversion of 1234
    vin = 16'd1234 ^ 16'h8000;
    start_i = 1'b1;
    exp_q.push_back(16'd1234); tag_q.push_back("R3 result 1234");
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 hold after start", {15'b0, hold_o}, 16'h1);
    chk("R2 busy_n after start", {15'b0, busy_n_o}, 16'h0);
    chk("R1 first trial", trial_o, 16'h8000);
    chk("R4 result kept", result_o, 16'h0000);
    @(negedge clk); @(negedge clk);
    chk("R1 trial held for a step", trial_o, 16'h8000);
    @(negedge clk);
    chk("R1 second trial", trial_o, 16'hC000);
    lowcnt = 3; res_last_low = result_o;
    chk("R4 result kept mid", result_o, 16'h0000);
    while (!busy_n_o) begin
      res_last_low = result_o;
      @(negedge clk);
      if (!busy_n_o) lowcnt++;
    end
    chk("R3 busy low cycles", 16'(lowcnt + 1), 16'(W * CPB + 1));
    chk("R3 result before busy rise", res_last_low, 16'd1234);
    chk("R6 hold low after end", {15'b0, hold_o}, 16'h0);
    last_res = 16'd1234;

    // R6 start inside acquisition window is ignored
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk("R6 start ignored busy_n", {15'b0, busy_n_o}, 16'h1);
    chk("R6 start ignored hold", {15'b0, hold_o}, 16'h0);
    repeat (ACQ + 1) @(negedge clk);

    // R7 coding corners
    run_conv(16'h7FFF, "R7 +full scale");
    run_conv(16'h0000, "R7 midscale");
    run_conv(16'hFFFF, "R7 one below mid");
    run_conv(16'h8000, "R7 -full scale");
    run_conv(16'h5A5A, "R3 pattern 5A5A");
    run_conv(16'hA5A5, "R3 pattern A5A5");

    // R5 abort by second start
    @(negedge clk);
    vin = 16'd100 ^ 16'h8000;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    exp_q.push_back(last_res); tag_q.push_back("R5 result after restart abort");
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R5 busy_n after restart", {15'b0, busy_n_o}, 16'h1);
    chk("R5 hold after restart", {15'b0, hold_o}, 16'h0);
    // R6 start after abort ignored
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk("R6 ignored after abort", {15'b0, busy_n_o}, 16'h1);
    repeat (ACQ + 1) @(negedge clk);
    run_conv(16'd100, "R5 conversion after abort");

    // R5 abort by abort pulse, at the first trial
    @(negedge clk);
    vin = 16'hF00D ^ 16'h8000;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    exp_q.push_back(last_res); tag_q.push_back("R5 result after abort pulse");
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    chk("R5 busy_n after abort", {15'b0, busy_n_o}, 16'h1);
    chk("R5 result after abort", result_o, last_res);
    repeat (ACQ + 1) @(negedge clk);

    // R9 abort while tracking
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    @(negedge clk);
    chk("R9 busy_n", {15'b0, busy_n_o}, 16'h1);
    chk("R9 hold", {15'b0, hold_o}, 16'h0);
    chk("R9 result", result_o, last_res);
    run_conv(16'hFFF0, "R9 conversion after idle abort");

    repeat (5) @(negedge clk);
    chk("R3 scoreboard drained", 16'(exp_q.size()), 16'h0);
    finish_run();
  end
endmodule